// File: doc/BRIEF.md
# Scintillator Coincidence and Level-1 Trigger Controller

This block turns hit lines from four time-of-flight scintillator planes and four calorimeter trigger lines, all already synchronous to the 100 MHz system clock, into the trigger sequence of the detector. Each input is stretched over a programmable coincidence window of one to three cycles. When at least three planes are active together, a one-cycle fast trigger is issued one clock later. The plane and calorimeter picture at that moment is snapshotted and kept for the event.

A fixed number of cycles after the fast trigger (100 by default, i.e. 1 µs), the snapshot is compared with a small table of value/mask entries written through a plain register port. On a match the block pulses the Level-1 accept together with a digitize-start strobe and raises BUSY in the same cycle. BUSY holds until every subdetector has raised its done line at least once after that start. Without a match the block falls back to idle silently. Fast triggers that arrive while BUSY is high are counted as dead time and start no evaluation. Fast triggers that arrive while an evaluation is pending are dropped.

All pins are plain control and status lines. No stream passes through the block, so no valid/ready pair exists and nothing can apply back-pressure. The only throttle on the trigger path is BUSY.

Top module: `coinc_trigger_ctrl`

## Requirements
- R1: When at least three of the four plane lines are active in the same cycle, `fast_trig` is high for exactly one cycle, in the cycle after the clock edge that first sees the coincidence. A plane is active in the cycle its line is high and for `win_len`-1 cycles after.
- R2: With only two planes active together, `fast_trig` stays low.
- R3: `win_len` sets the coincidence window to 1, 2 or 3 cycles, and the value 0 acts as 1. Hits on planes one cycle apart coincide with a window of 2 but not with a window of 1.
- R4: The snapshot is 8 bits: bits 3:0 are the active planes 0..3 and bits 7:4 are the active calorimeter lines 0..3. If the snapshot matches an entry, `l1_accept` is high for one cycle exactly `L1_LAT` cycles after the `fast_trig` cycle. A match means the entry is valid and ((snapshot XOR value) AND mask) is zero.
- R5: If no entry matches at the decision cycle, none of `l1_accept`, `digitize_start` or `busy` rises, and the block is idle again.
- R6: A write with `cfg_we` high stores `cfg_valid`, `cfg_value` and `cfg_mask` into entry `cfg_addr`. After reset all entries are invalid, and an invalidated entry no longer matches.
- R7: `digitize_start` pulses in the same cycle as `l1_accept`, and `busy` is high from that cycle on.
- R8: `busy` falls only after each of the subdetector done lines has been seen high on some clock edge after the accept cycle, in any order or overlap. Done lines high before or during the accept edge do not count.
- R9: A fast trigger while `busy` is high still pulses `fast_trig`, increments the saturating `dead_cnt` one cycle later, and never leads to `l1_accept`.
- R10: A fast trigger that arrives while an evaluation is pending neither replaces the pending snapshot nor is counted in `dead_cnt`.
- R11: After reset, `fast_trig`, `l1_accept`, `digitize_start` and `busy` are low and `dead_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 100 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| plane_hit | input | 4 | Synchronized time-of-flight plane hit lines |
| calo_hit | input | 4 | Synchronized calorimeter trigger lines |
| win_len | input | 2 | Coincidence window in cycles (0 treated as 1) |
| cfg_we | input | 1 | Pattern table write strobe |
| cfg_addr | input | 3 | Pattern entry index |
| cfg_valid | input | 1 | Valid flag written to the entry |
| cfg_value | input | 8 | Required snapshot bits |
| cfg_mask | input | 8 | Snapshot bits that are compared |
| subdet_done | input | 4 | Readout-complete lines, one per subdetector |
| fast_trig | output | 1 | One-cycle fast trigger pulse |
| l1_accept | output | 1 | One-cycle Level-1 accept pulse |
| digitize_start | output | 1 | One-cycle strobe that starts digitization everywhere |
| busy | output | 1 | Readout in progress, new events blocked |
| dead_cnt | output | 16 | Saturating count of fast triggers lost to BUSY |

## Verification
A wrong window counter shows at the next hit as a missing or extra `fast_trig`, one cycle after the second plane is hit. A latency counter that is off by one moves `l1_accept` away from its exact cycle 100 cycles later, and the bench checks the whole span for early pulses. A snapshot overwritten during the wait, or done flags kept from an older event, change the Level-1 decision or the release of `busy` in the same event. Those are seen within one latency window or one done sequence.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int unsigned PLANES_DEF = 4;
  localparam int unsigned CALO_DEF   = 4;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } l1_state_t;
endpackage

// File: rtl/coinc_majority.sv
module coinc_majority #(
  parameter int unsigned N_PLANES = 4,
  parameter int unsigned N_CALO   = 4,
  parameter int unsigned MAJ      = 3,
  parameter int unsigned WIN_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PLANES-1:0]        plane_hit,
  input  logic [N_CALO-1:0]          calo_hit,
  input  logic [WIN_W-1:0]           win_len,
  output logic                       fast_trig,
  output logic [N_PLANES+N_CALO-1:0] snap
);
  localparam int unsigned NIN   = N_PLANES + N_CALO;
  localparam int unsigned CNT_W = $clog2(N_PLANES + 1);

  logic [NIN-1:0]   raw;
  logic [NIN-1:0]   act;
  logic [WIN_W-1:0] win_eff;
  logic [CNT_W-1:0] n_act;
  logic             coin, coin_q;

  assign raw     = {calo_hit, plane_hit};
  assign win_eff = (win_len == '0) ? WIN_W'(1) : win_len;

  // each line keeps its hit alive for win_eff cycles in total
  for (genvar i = 0; i < NIN; i++) begin : g_stretch
    logic [WIN_W-1:0] age;
    always_ff @(posedge clk) begin
      if (!rst_n)             age <= '0;
      else if (raw[i])        age <= win_eff - WIN_W'(1);
      else if (age != '0)     age <= age - WIN_W'(1);
    end
    assign act[i] = raw[i] | (age != '0);
  end

  always_comb begin
    n_act = '0;
    for (int p = 0; p < N_PLANES; p++) n_act = n_act + CNT_W'(act[p]);
  end

  assign coin = (n_act >= CNT_W'(MAJ));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coin_q    <= 1'b0;
      fast_trig <= 1'b0;
      snap      <= '0;
    end else begin
      coin_q    <= coin;
      fast_trig <= coin & ~coin_q;
      if (coin & ~coin_q) snap <= act;
    end
  end

  // R1
  fast_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_trig |=> !fast_trig);
endmodule

// File: rtl/coinc_pattern_table.sv
module coinc_pattern_table #(
  parameter int unsigned PAT_W = 8,
  parameter int unsigned N_PAT = 8,
  localparam int unsigned AW   = (N_PAT > 1) ? $clog2(N_PAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic             cfg_valid,
  input  logic [PAT_W-1:0] cfg_value,
  input  logic [PAT_W-1:0] cfg_mask,
  input  logic [PAT_W-1:0] probe,
  output logic             hit
);
  logic [N_PAT-1:0] vld;
  logic [PAT_W-1:0] val [N_PAT];
  logic [PAT_W-1:0] msk [N_PAT];
  logic [N_PAT-1:0] match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int e = 0; e < N_PAT; e++) begin
        val[e] <= '0;
        msk[e] <= '0;
      end
    end else if (cfg_we) begin
      for (int e = 0; e < N_PAT; e++) begin
        if (cfg_addr == AW'(e)) begin
          vld[e] <= cfg_valid;
          val[e] <= cfg_value;
          msk[e] <= cfg_mask;
        end
      end
    end
  end

  always_comb begin
    for (int e = 0; e < N_PAT; e++)
      match[e] = vld[e] & (((probe ^ val[e]) & msk[e]) == '0);
  end

  assign hit = |match;

  // R6
  no_hit_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == '0) |-> !hit);
endmodule

// File: rtl/coinc_readout_interlock.sv
module coinc_readout_interlock #(
  parameter int unsigned N_SUB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_SUB-1:0] done,
  output logic             busy
);
  logic [N_SUB-1:0] seen;
  logic [N_SUB-1:0] seen_nxt;

  assign seen_nxt = seen | done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      seen <= '0;
    end else if (start) begin
      busy <= 1'b1;
      seen <= '0;
    end else if (busy) begin
      if (&seen_nxt) begin
        busy <= 1'b0;
        seen <= '0;
      end else begin
        seen <= seen_nxt;
      end
    end
  end

  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(|done));
endmodule

// File: rtl/coinc_trigger_ctrl.sv
module coinc_trigger_ctrl
  import coinc_pkg::*;
#(
  parameter int unsigned N_PLANES = PLANES_DEF,
  parameter int unsigned N_CALO   = CALO_DEF,
  parameter int unsigned MAJ      = 3,
  parameter int unsigned WIN_W    = 2,
  parameter int unsigned N_PAT    = 8,
  parameter int unsigned L1_LAT   = 100,
  parameter int unsigned N_SUB    = 4,
  parameter int unsigned DEAD_W   = 16,
  localparam int unsigned PAT_W   = N_PLANES + N_CALO,
  localparam int unsigned PAT_AW  = (N_PAT > 1) ? $clog2(N_PAT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PLANES-1:0] plane_hit,
  input  logic [N_CALO-1:0] calo_hit,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              cfg_we,
  input  logic [PAT_AW-1:0] cfg_addr,
  input  logic              cfg_valid,
  input  logic [PAT_W-1:0]  cfg_value,
  input  logic [PAT_W-1:0]  cfg_mask,
  input  logic [N_SUB-1:0]  subdet_done,
  output logic              fast_trig,
  output logic              l1_accept,
  output logic              digitize_start,
  output logic              busy,
  output logic [DEAD_W-1:0] dead_cnt
);
  localparam int unsigned LAT_W = $clog2(L1_LAT + 1);

  l1_state_t        state;
  logic [LAT_W-1:0] lat_cnt;
  logic [PAT_W-1:0] snap;
  logic [PAT_W-1:0] evt_pat;
  logic             pat_hit;
  logic             fire;

  coinc_majority #(
    .N_PLANES(N_PLANES), .N_CALO(N_CALO), .MAJ(MAJ), .WIN_W(WIN_W)
  ) u_major (
    .clk(clk), .rst_n(rst_n), .plane_hit(plane_hit), .calo_hit(calo_hit),
    .win_len(win_len), .fast_trig(fast_trig), .snap(snap)
  );

  coinc_pattern_table #(
    .PAT_W(PAT_W), .N_PAT(N_PAT)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_valid(cfg_valid), .cfg_value(cfg_value), .cfg_mask(cfg_mask),
    .probe(evt_pat), .hit(pat_hit)
  );

  coinc_readout_interlock #(
    .N_SUB(N_SUB)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .start(fire), .done(subdet_done), .busy(busy)
  );

  assign fire = (state == ST_WAIT) && (lat_cnt == LAT_W'(1)) && pat_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      lat_cnt        <= '0;
      evt_pat        <= '0;
      l1_accept      <= 1'b0;
      digitize_start <= 1'b0;
      dead_cnt       <= '0;
    end else begin
      l1_accept      <= fire;
      digitize_start <= fire;
      if (fast_trig && busy && (dead_cnt != '1))
        dead_cnt <= dead_cnt + DEAD_W'(1);
      case (state)
        ST_IDLE: begin
          if (fast_trig && !busy) begin
            state   <= ST_WAIT;
            lat_cnt <= LAT_W'(L1_LAT - 1);
            evt_pat <= snap;
          end
        end
        ST_WAIT: begin
          if (lat_cnt == LAT_W'(1)) state <= ST_IDLE;
          else                      lat_cnt <= lat_cnt - LAT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  accept_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_accept |-> $past(state == ST_WAIT));

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_accept |-> busy);

  // R9
  dead_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_trig && busy) |=> (dead_cnt != '0));

  // R10
  wait_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !busy);
endmodule

// File: tb/coinc_trigger_ctrl_bench.sv
module coinc_trigger_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int LAT   = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] plane_hit, calo_hit, subdet_done;
  logic [1:0] win_len;
  logic       cfg_we, cfg_valid;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_value, cfg_mask;
  logic       fast_trig, l1_accept, digitize_start, busy;
  logic [15:0] dead_cnt;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  coinc_trigger_ctrl u_coinc_trigger_ctrl (
    .clk(clk), .rst_n(rst_n), .plane_hit(plane_hit), .calo_hit(calo_hit),
    .win_len(win_len), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_valid(cfg_valid), .cfg_value(cfg_value), .cfg_mask(cfg_mask),
    .subdet_done(subdet_done), .fast_trig(fast_trig), .l1_accept(l1_accept),
    .digitize_start(digitize_start), .busy(busy), .dead_cnt(dead_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) step();
  endtask

  // drive one-cycle hit; returns at the negedge where fast_trig is visible
  task automatic hit(input logic [3:0] p, input logic [3:0] c);
    plane_hit = p; calo_hit = c;
    step();
    plane_hit = '0; calo_hit = '0;
  endtask

  task automatic write_entry(input int a, input logic v, input logic [7:0] val, input logic [7:0] m);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_valid = v; cfg_value = val; cfg_mask = m;
    step();
    cfg_we = 1'b0;
  endtask

  // called at the negedge where fast_trig was seen
  task automatic wait_l1(input logic exp, input string req);
    logic early = 1'b0;
    for (int j = 1; j < LAT; j++) begin
      step();
      if (l1_accept) early = 1'b1;
    end
    chk({req, " no early accept"}, early, 1'b0);
    step();
    chk({req, " l1_accept at latency"}, l1_accept, exp);
    chk({req, " digitize_start with accept"}, digitize_start, exp);
    chk({req, " busy at accept"}, busy, exp);
  endtask

  task automatic release_all();
    subdet_done = 4'hF;
    step();
    subdet_done = '0;
    chk("R8 busy cleared after all done", busy, 1'b0);
    idle(4);
  endtask

  task automatic t_reset();
    chk("R11 fast_trig reset", fast_trig, 1'b0);
    chk("R11 l1_accept reset", l1_accept, 1'b0);
    chk("R11 digitize_start reset", digitize_start, 1'b0);
    chk("R11 busy reset", busy, 1'b0);
    chk("R11 dead_cnt reset", dead_cnt, 0);
  endtask

  task automatic t_empty_table();
    win_len = 2'd1;
    hit(4'h7, 4'h0);
    chk("R1 fast_trig on three planes", fast_trig, 1'b1);
    step();
    chk("R1 fast_trig single cycle", fast_trig, 1'b0);
    idle(LAT + 5);
    chk("R6 empty table gives no busy", busy, 1'b0);
  endtask

  task automatic t_two_planes();
    logic seen = 1'b0;
    hit(4'h3, 4'hF);
    if (fast_trig) seen = 1'b1;
    step();
    if (fast_trig) seen = 1'b1;
    chk("R2 two planes no fast_trig", seen, 1'b0);
    idle(3);
  endtask

  task automatic t_window();
    logic seen;
    foreach (seen_w[k]) ;
    // window 1: planes one cycle apart do not coincide
    win_len = 2'd1;
    seen = 1'b0;
    plane_hit = 4'h3; step(); plane_hit = 4'h4; step(); plane_hit = '0;
    if (fast_trig) seen = 1'b1;
    step(); if (fast_trig) seen = 1'b1;
    chk("R3 window 1 separates hits", seen, 1'b0);
    idle(4);
    // window 0 behaves like 1
    win_len = 2'd0;
    seen = 1'b0;
    plane_hit = 4'h3; step(); plane_hit = 4'h4; step(); plane_hit = '0;
    if (fast_trig) seen = 1'b1;
    step(); if (fast_trig) seen = 1'b1;
    chk("R3 window 0 acts as 1", seen, 1'b0);
    idle(4);
    // window 2 joins them; snapshot 07 matches entry 0
    win_len = 2'd2;
    plane_hit = 4'h3; step(); plane_hit = 4'h4; step(); plane_hit = '0;
    chk("R3 window 2 joins hits", fast_trig, 1'b1);
    wait_l1(1'b1, "R3");
    release_all();
    win_len = 2'd1;
  endtask

  logic seen_w [1];

  task automatic t_accept_and_done();
    logic early = 1'b0;
    hit(4'h7, 4'h0);
    chk("R1 fast_trig before accept", fast_trig, 1'b1);
    for (int j = 1; j < LAT; j++) begin
      subdet_done = (j == 50) ? 4'hF : 4'h0;
      step();
      if (l1_accept) early = 1'b1;
    end
    subdet_done = '0;
    chk("R4 no early accept", early, 1'b0);
    step();
    chk("R4 l1_accept exact latency", l1_accept, 1'b1);
    chk("R7 digitize_start with accept", digitize_start, 1'b1);
    chk("R7 busy with accept", busy, 1'b1);
    step();
    chk("R4 l1_accept one cycle", l1_accept, 1'b0);
    idle(2);
    chk("R8 done before accept ignored", busy, 1'b1);
    subdet_done = 4'h1; step(); subdet_done = '0;
    chk("R8 one done keeps busy", busy, 1'b1);
    idle(3);
    subdet_done = 4'hC; step(); subdet_done = '0;
    chk("R8 three done keeps busy", busy, 1'b1);
    subdet_done = 4'h2; step(); subdet_done = '0;
    chk("R8 last done clears busy", busy, 1'b0);
    idle(4);
  endtask

  task automatic t_dead_time();
    logic acc = 1'b0;
    hit(4'h7, 4'h0);
    wait_l1(1'b1, "R9 setup");
    idle(3);
    hit(4'hF, 4'h0);
    chk("R9 fast_trig while busy", fast_trig, 1'b1);
    step();
    chk("R9 dead_cnt increments", dead_cnt, 1);
    for (int j = 0; j < LAT + 5; j++) begin
      step();
      if (l1_accept) acc = 1'b1;
    end
    chk("R9 no accept from dead trigger", acc, 1'b0);
    chk("R9 busy still held", busy, 1'b1);
    release_all();
  endtask

  task automatic t_no_match();
    hit(4'hB, 4'h0);
    chk("R5 fast_trig for 0B", fast_trig, 1'b1);
    wait_l1(1'b0, "R5");
    step();
    chk("R5 idle with busy low", busy, 1'b0);
  endtask

  task automatic t_calo_match();
    hit(4'hB, 4'h1);
    wait_l1(1'b1, "R4 calo bit 4");
    release_all();
  endtask

  task automatic t_invalidate();
    write_entry(1, 1'b0, 8'h10, 8'h10);
    hit(4'hB, 4'h1);
    wait_l1(1'b0, "R6 invalidated entry");
  endtask

  task automatic t_wait_ignore();
    logic acc = 1'b0;
    logic [15:0] d0;
    d0 = dead_cnt;
    hit(4'hB, 4'h0);
    for (int j = 1; j < 2 * LAT + 10; j++) begin
      plane_hit = (j == 20) ? 4'h7 : 4'h0;
      step();
      if (l1_accept) acc = 1'b1;
    end
    plane_hit = '0;
    chk("R10 pending snapshot kept", acc, 1'b0);
    chk("R10 dead_cnt unchanged", dead_cnt, 32'(d0));
    chk("R10 busy low", busy, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    plane_hit = '0; calo_hit = '0; subdet_done = '0; win_len = 2'd1;
    cfg_we = 1'b0; cfg_addr = '0; cfg_valid = 1'b0; cfg_value = '0; cfg_mask = '0;
    idle(4);
    rst_n = 1'b1;
    step();
    t_reset();
    t_empty_table();
    write_entry(0, 1'b1, 8'h07, 8'h0F);
    write_entry(1, 1'b1, 8'h10, 8'h10);
    t_two_planes();
    t_window();
    t_accept_and_done();
    t_dead_time();
    t_no_match();
    t_calo_match();
    t_invalidate();
    t_wait_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule